// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits between a host's byte-write stream and the page loader of a byte-wide flash array. It watches every write strobe together with its address and data, and recognises multi-cycle unlock patterns built from fixed address and data pairs. Three-cycle patterns switch write protection on and open a page-load window, or leave identification mode. Six-cycle patterns switch protection off, start a full-chip erase, or enter identification mode.

The block keeps a protection flag. A power-up reset sets this flag, and the ordinary reset leaves it alone. While the flag is set, a data write reaches the page loader only inside a load window that the three-cycle protect prefix opens. The window stays open while writes keep arriving and closes after a run of idle cycles. Inside the window, every write counts as page data and none is decoded as a command. In identification mode, reads return a manufacturer byte and a device byte. The erase itself and its timing belong to a neighbouring block. This block only produces the start pulse.

Top module: `unlock_seq_decoder`

## Requirements
- R1: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, each consumed and never granted, set protect_on and open a load window from the next cycle. Writes inside that window assert wr_grant in the same cycle.
- R2: After power-up reset, protect_on is 1. With protection on and no window open, an ordinary write gives wr_grant=0. With protection off, an ordinary write gives wr_grant=1 in the same cycle.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear protect_on on the cycle after the last of them.
- R4: The same six-write pattern ending in 10h@5555h raises erase_start for exactly one cycle, the cycle after the last write.
- R5: The six-write pattern ending in 60h@5555h sets id_mode. While id_mode is 1, a read (rd_en=1) returns DAh at address 0, C1h at address 1 and 00h elsewhere on id_rdata in the same cycle. Outside identification mode, id_rdata is 00h.
- R6: The writes AAh@5555h, 55h@2AAAh, F0h@5555h clear id_mode on the next cycle.
- R7: pwr_rst sets protect_on to 1 and clears id_mode. rst clears id_mode, the decoder state and the window, and leaves protect_on unchanged.
- R8: Command addresses are compared on address bits 14:0 only. Bits 16:15 are ignored and bit 14 is significant.
- R9: A write that does not match the next expected cycle returns the decoder to idle. That write is treated as an ordinary write under the protection gate. A write that matches a command cycle is never granted.
- R10: The load window closes once GAP_CYCLES consecutive cycles pass without a write. A write in the cycle that follows is then blocked when protection is on. Writes inside the window are not decoded, so AAh@5555h there is granted as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; keeps the protection flag |
| pwr_rst | input | 1 | Synchronous active-high power-up reset; sets the protection flag |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (17) | Byte address |
| wdata | input | DATA_W (8) | Write data |
| wr_grant | output | 1 | This cycle's write is passed to the page loader |
| erase_start | output | 1 | One-cycle pulse requesting a chip erase |
| id_mode | output | 1 | Identification mode is active |
| id_rdata | output | DATA_W (8) | Identification byte for the current read |
| protect_on | output | 1 | Write protection flag |

## Verification
The bench goes after the transitions where a decoder usually slips.

- A broken prefix must leave the decoder idle. A design that resynchronised on the breaking write would accept a later A0h and open a window it should not.
- Data writes in the window must bypass decoding. A design that decoded them would swallow a page byte of AAh at 5555h.
- The window must close after exactly the idle run. An off-by-one gap counter would grant or block the boundary write wrongly.
- The bench checks that a warm reset keeps protection and that a power-up reset restores it. It also checks that the erase pulse lasts exactly one cycle and that address bit 14 takes part in the command compare.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W_DEF = 17;
    localparam int DATA_W_DEF = 8;
    localparam int CMP_W_DEF  = 15;

    localparam logic [14:0] CMD_ADDR_A = 15'h5555;
    localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_LOCK    = 8'hA0;
    localparam logic [7:0] OP_LONG    = 8'h80;
    localparam logic [7:0] OP_ID_OUT  = 8'hF0;
    localparam logic [7:0] OP_UNLOCK  = 8'h20;
    localparam logic [7:0] OP_ERASE   = 8'h10;
    localparam logic [7:0] OP_ID_IN   = 8'h60;

    localparam logic [7:0] ID_VENDOR = 8'hDA;
    localparam logic [7:0] ID_PART   = 8'hC1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_LONG,
        SQ_K4,
        SQ_K5
    } seq_state_e;

    typedef struct packed {
        logic lock;
        logic unlock;
        logic erase;
        logic id_in;
        logic id_out;
    } cmd_evt_t;

endpackage

// File: rtl/useq_fsm.sv
module useq_fsm
    import useq_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CMP_W  = CMP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              bypass,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              consume,
    output cmd_evt_t          evt,
    output logic              erase_start
);

    seq_state_e st, nxt;
    logic [CMP_W-1:0] cmp_addr;
    logic at_a, at_b, live;

    assign cmp_addr = addr[CMP_W-1:0];
    assign at_a     = (cmp_addr == CMP_W'(CMD_ADDR_A));
    assign at_b     = (cmp_addr == CMP_W'(CMD_ADDR_B));
    assign live     = wr_en && !bypass && !rst;

    always_comb begin
        nxt     = st;
        consume = 1'b0;
        evt     = '0;
        if (live) begin
            nxt = SQ_IDLE;
            unique case (st)
                SQ_IDLE: if (at_a && wdata == DATA_W'(KEY_FIRST)) begin
                    nxt = SQ_K1; consume = 1'b1;
                end
                SQ_K1: if (at_b && wdata == DATA_W'(KEY_SECOND)) begin
                    nxt = SQ_K2; consume = 1'b1;
                end
                SQ_K2: if (at_a) begin
                    if (wdata == DATA_W'(OP_LOCK)) begin
                        evt.lock = 1'b1; consume = 1'b1;
                    end else if (wdata == DATA_W'(OP_ID_OUT)) begin
                        evt.id_out = 1'b1; consume = 1'b1;
                    end else if (wdata == DATA_W'(OP_LONG)) begin
                        nxt = SQ_LONG; consume = 1'b1;
                    end
                end
                SQ_LONG: if (at_a && wdata == DATA_W'(KEY_FIRST)) begin
                    nxt = SQ_K4; consume = 1'b1;
                end
                SQ_K4: if (at_b && wdata == DATA_W'(KEY_SECOND)) begin
                    nxt = SQ_K5; consume = 1'b1;
                end
                SQ_K5: if (at_a) begin
                    if (wdata == DATA_W'(OP_UNLOCK)) begin
                        evt.unlock = 1'b1; consume = 1'b1;
                    end else if (wdata == DATA_W'(OP_ERASE)) begin
                        evt.erase = 1'b1; consume = 1'b1;
                    end else if (wdata == DATA_W'(OP_ID_IN)) begin
                        evt.id_in = 1'b1; consume = 1'b1;
                    end
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SQ_IDLE;
            erase_start <= 1'b0;
        end else begin
            st          <= nxt;
            erase_start <= evt.erase;
        end
    end

    p_erase_single_r4: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    p_evt_needs_consume_r9: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |-> consume);

endmodule

// File: rtl/useq_gate.sv
module useq_gate #(
    parameter int GAP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_rst,
    input  logic wr_en,
    input  logic consume,
    input  logic lock,
    input  logic unlock,
    output logic grant,
    output logic protect,
    output logic window
);

    localparam int CNT_W = $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (pwr_rst)     protect <= 1'b1;
        else if (lock)   protect <= 1'b1;
        else if (unlock) protect <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_rst) begin
            window   <= 1'b0;
            idle_cnt <= '0;
        end else if (lock) begin
            window   <= 1'b1;
            idle_cnt <= '0;
        end else if (window) begin
            if (wr_en) begin
                idle_cnt <= '0;
            end else if (idle_cnt == CNT_W'(GAP_CYCLES - 1)) begin
                window   <= 1'b0;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assign grant = wr_en && !consume && (!protect || window);

    p_lock_opens_r1: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        lock |=> (protect && window));

    p_unlock_clears_r3: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        unlock |=> !protect);

    p_window_protected_r10: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        window |-> protect);

    p_rst_keeps_flag_r7: assert property (@(posedge clk) disable iff (pwr_rst)
        rst |=> $stable(protect));

endmodule

// File: rtl/useq_idrom.sv
module useq_idrom
    import useq_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_in,
    input  logic              id_out,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rdata
);

    always_ff @(posedge clk) begin
        if (rst)         id_mode <= 1'b0;
        else if (id_in)  id_mode <= 1'b1;
        else if (id_out) id_mode <= 1'b0;
    end

    always_comb begin
        id_rdata = '0;
        if (id_mode && rd_en) begin
            if (addr == ADDR_W'(0))      id_rdata = DATA_W'(ID_VENDOR);
            else if (addr == ADDR_W'(1)) id_rdata = DATA_W'(ID_PART);
        end
    end

    p_id_enter_r5: assert property (@(posedge clk) disable iff (rst)
        id_in |=> id_mode);

    p_id_leave_r6: assert property (@(posedge clk) disable iff (rst)
        id_out |=> !id_mode);

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import useq_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int CMP_W      = CMP_W_DEF,
    parameter int GAP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_grant,
    output logic              erase_start,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rdata,
    output logic              protect_on
);

    logic     warm;
    logic     consume;
    logic     window;
    cmd_evt_t evt;

    assign warm = rst || pwr_rst;

    useq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) fsm_i (
        .clk(clk), .rst(warm), .wr_en(wr_en), .bypass(window),
        .addr(addr), .wdata(wdata), .consume(consume), .evt(evt),
        .erase_start(erase_start)
    );

    useq_gate #(.GAP_CYCLES(GAP_CYCLES)) gate_i (
        .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .wr_en(wr_en),
        .consume(consume), .lock(evt.lock), .unlock(evt.unlock),
        .grant(wr_grant), .protect(protect_on), .window(window)
    );

    useq_idrom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) idrom_i (
        .clk(clk), .rst(warm), .id_in(evt.id_in), .id_out(evt.id_out),
        .rd_en(rd_en), .addr(addr), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    p_cmd_not_granted_r9: assert property (@(posedge clk) disable iff (warm)
        consume |-> !wr_grant);

endmodule

// File: tb/unlock_seq_decoder_tb.sv
`timescale 1ns/1ps
module unlock_seq_decoder_tb_top;

    localparam int GAP = 16;
    localparam int K_GRANT = 0, K_PROT = 1, K_ID = 2, K_ERASE = 3, K_RD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        pwr_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_grant, erase_start, id_mode, protect_on;
    logic [7:0]  id_rdata;

    always #2.5 clk = ~clk;

    unlock_seq_decoder #(.GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .wr_grant(wr_grant), .erase_start(erase_start),
        .id_mode(id_mode), .id_rdata(id_rdata), .protect_on(protect_on)
    );

    typedef struct {
        int         tgt;
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] observe(int kind);
        case (kind)
            K_GRANT: return {7'b0, wr_grant};
            K_PROT:  return {7'b0, protect_on};
            K_ID:    return {7'b0, id_mode};
            K_ERASE: return {7'b0, erase_start};
            default: return id_rdata;
        endcase
    endfunction

    // monitor: pops expected items when their cycle comes
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].tgt <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                act = observe(it.kind);
                checks++;
                if (it.tgt != cyc || act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_at(int dly, int kind, logic [7:0] exp, string tag);
        q.push_back('{cyc + dly, kind, exp, tag});
    endtask

    task automatic wr(logic [16:0] a, logic [7:0] d, logic g, string tag);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        expect_at(0, K_GRANT, {7'b0, g}, tag);
    endtask

    task automatic rd(logic [16:0] a, logic [7:0] e, string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        expect_at(0, K_RD, e, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic cmd3(logic [16:0] aa, logic [16:0] ab, logic [7:0] op, string tag);
        wr(aa, 8'hAA, 1'b0, tag);
        wr(ab, 8'h55, 1'b0, tag);
        wr(aa, op, 1'b0, tag);
    endtask

    task automatic cmd6(logic [7:0] op, string tag);
        wr(17'h05555, 8'hAA, 1'b0, tag);
        wr(17'h02AAA, 8'h55, 1'b0, tag);
        wr(17'h05555, 8'h80, 1'b0, tag);
        wr(17'h05555, 8'hAA, 1'b0, tag);
        wr(17'h02AAA, 8'h55, 1'b0, tag);
        wr(17'h05555, op, 1'b0, tag);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        pwr_rst = 1'b0;
        // R7: power-up state
        expect_at(0, K_PROT, 8'h01, "R7 power-up protect");
        expect_at(0, K_ID, 8'h00, "R7 power-up id_mode");
        expect_at(0, K_ERASE, 8'h00, "R4 no erase after reset");
        idle(1);

        // R2: protected, no window
        wr(17'h00100, 8'h12, 1'b0, "R2 protected write blocked");

        // R1: prefix opens window
        cmd3(17'h05555, 17'h02AAA, 8'hA0, "R1 prefix consumed");
        expect_at(1, K_PROT, 8'h01, "R1 protect after prefix");
        wr(17'h00100, 8'h01, 1'b1, "R1 window write 0");
        wr(17'h00101, 8'h02, 1'b1, "R1 window write 1");
        wr(17'h00102, 8'h03, 1'b1, "R1 window write 2");
        idle(3);
        wr(17'h05555, 8'hAA, 1'b1, "R10 command byte in window is data");
        idle(GAP + 2);
        wr(17'h00103, 8'h04, 1'b0, "R10 window closed");

        // R9: broken prefix while protected
        wr(17'h05555, 8'hAA, 1'b0, "R9 first key");
        wr(17'h02AAA, 8'h55, 1'b0, "R9 second key");
        wr(17'h03333, 8'h44, 1'b0, "R9 mismatch gated by protection");
        wr(17'h02AAA, 8'h55, 1'b0, "R9 idle after mismatch");
        wr(17'h05555, 8'hA0, 1'b0, "R9 stray opcode ignored");
        wr(17'h00200, 8'h66, 1'b0, "R9 no window opened");

        // R3: disable protection
        cmd6(8'h20, "R3 unlock consumed");
        expect_at(1, K_PROT, 8'h00, "R3 protect cleared");
        wr(17'h00300, 8'h5A, 1'b1, "R2 unprotected write granted");

        // R9 unprotected mismatch
        wr(17'h05555, 8'hAA, 1'b0, "R9 key consumed");
        wr(17'h00123, 8'h77, 1'b1, "R9 mismatch becomes ordinary write");

        // R8: bit 14 significant, bits 16:15 ignored
        wr(17'h01555, 8'hAA, 1'b1, "R8 bit14 clear is not command");
        cmd3(17'h1D555, 17'h1AAAA, 8'hA0, "R8 high address bits ignored");
        expect_at(1, K_PROT, 8'h01, "R8 prefix via aliased address");
        wr(17'h00400, 8'h11, 1'b1, "R8 window open");
        idle(GAP + 2);

        // R4: erase pulse
        cmd6(8'h10, "R4 erase consumed");
        expect_at(1, K_ERASE, 8'h01, "R4 erase pulse high");
        idle(1);
        expect_at(1, K_ERASE, 8'h00, "R4 erase pulse one cycle");
        idle(1);

        // R5: identification mode
        rd(17'h00000, 8'h00, "R5 no id data outside mode");
        cmd6(8'h60, "R5 id entry consumed");
        expect_at(1, K_ID, 8'h01, "R5 id_mode set");
        rd(17'h00000, 8'hDA, "R5 vendor byte");
        rd(17'h00001, 8'hC1, "R5 part byte");
        rd(17'h00002, 8'h00, "R5 other address");

        // R6: leave identification mode
        cmd3(17'h05555, 17'h02AAA, 8'hF0, "R6 id exit consumed");
        expect_at(1, K_ID, 8'h00, "R6 id_mode cleared");
        rd(17'h00000, 8'h00, "R6 no id data after exit");
        idle(GAP + 2);

        // R7: warm reset keeps protection, power reset restores it
        cmd6(8'h20, "R7 unlock");
        cmd6(8'h60, "R7 id entry");
        expect_at(1, K_ID, 8'h01, "R7 id_mode before reset");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rst = 1'b1;
        expect_at(1, K_PROT, 8'h00, "R7 warm reset keeps protect");
        expect_at(1, K_ID, 8'h00, "R7 warm reset clears id_mode");
        @(negedge clk);
        rst = 1'b0;
        pwr_rst = 1'b1;
        expect_at(1, K_PROT, 8'h01, "R7 power reset sets protect");
        @(negedge clk);
        pwr_rst = 1'b0;
        idle(4);

        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items actual=%0d expected=0", q.size(), q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule